// File: doc/BRIEF.md
# Audio Clock Supervisor and Power-Up Sequencer

The block watches three externally supplied audio clocks (the master clock, the bit clock and the frame clock) from a free-running reference clock. From the number of master-clock edges that fall in one frame it works out whether the stream runs at normal, double or quad rate. It then drives the enables that bring the data path up in order: an analog enable after a fixed settling delay once the master clock is running, a digital enable a few frames after a valid rate has been measured, and an output mute that stays set for a rate-dependent number of frames before real samples pass.

When any clock stops, or the measured ratio stops matching the rate in use, the block drops the digital path back to reset and forces the output mute. Once all clocks run again with a legal ratio, it repeats the sequence by itself. Nothing is configured at run time; limits and delays are parameters sized for the reference clock.

Top module: `audio_clk_supervisor`

## Requirements
- R1: While rst_ni is low and until the sequence completes, dig_en_o is 0 and mute_o is 1; ana_en_o is 0 and speed_o is 0 out of reset.
- R2: A frame holding 512, 768 or 1152 master-clock rising edges, each within plus or minus TOL, is a normal-rate frame and sets speed_o to 0.
- R3: A frame holding 256 or 384 edges (within TOL) sets speed_o to 1 (double rate); 128 or 192 edges set speed_o to 2 (quad rate).
- R4: A frame whose edge count matches none of the seven ratios keeps dig_en_o at 0 and mute_o at 1.
- R5: A clock that shows no rising edge for its timeout (in reference cycles) is dead; while any clock is dead, dig_en_o is 0 and mute_o is 1.
- R6: Once all three clocks run again with a legal ratio, the sequence restarts with no outside action.
- R7: With all clocks present, the first frame edge opens a measurement window, the next closes it, and dig_en_o rises DIG_FRAMES frame edges after that accepted measurement (the fourth frame edge after clock start with the default of 2).
- R8: After dig_en_o rises, mute_o stays 1 for MUTE_BASE frame edges at normal rate, twice that at double rate and four times that at quad rate, then falls; speed_o does not change while dig_en_o is 1.
- R9: ana_en_o rises ANA_DLY reference cycles after the master clock is detected and falls when the master clock is dead, whatever the other two clocks do.
- R10: A measurement that fails to match, or matches a different rate, on the same frame edge that would end the mute hold takes precedence: dig_en_o falls and mute_o never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_i | input | 1 | Master clock, asynchronous to clk_i |
| bclk_i | input | 1 | Bit clock, asynchronous to clk_i |
| fclk_i | input | 1 | Frame clock, asynchronous to clk_i |
| speed_o | output | 2 | Rate code: 0 normal, 1 double, 2 quad |
| dig_en_o | output | 1 | Digital path enable |
| ana_en_o | output | 1 | Analog path enable |
| mute_o | output | 1 | Output forced to zero when 1 |

## Verification
The expiry of the mute hold and the detection of a ratio change are both evaluated on a frame edge, so they can land in the same reference cycle. The bench provokes this by switching the generated ratio from 512 to 256 so that the first short frame closes exactly on the edge that would end a normal-rate hold. It judges the outcome by requiring that mute_o never falls, that dig_en_o drops on that exact frame edge, and that the block then comes back up at double rate with a doubled hold.

// File: rtl/acs_pkg.sv
package acs_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAIT,
    ST_MUTE,
    ST_RUN
  } seq_state_e;

  localparam int unsigned N_RATIO = 7;

  function automatic int unsigned ratio_tab(input int unsigned idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction

  function automatic speed_e speed_tab(input int unsigned idx);
    if (idx < 2)      return SPD_QUAD;
    else if (idx < 4) return SPD_DOUBLE;
    else              return SPD_NORMAL;
  endfunction

endpackage

// File: rtl/acs_edge_mon.sv
module acs_edge_mon #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic alive_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TO_V = TW'(TIMEOUT);

  logic s1_q, s2_q, s3_q;
  logic [TW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  // starts saturated: dead until the first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            idle_q <= TO_V;
    else if (rise_o)        idle_q <= '0;
    else if (idle_q != TO_V) idle_q <= idle_q + 1'b1;
  end

  assign alive_o = (idle_q != TO_V);

endmodule

// File: rtl/acs_ratio_meas.sv
module acs_ratio_meas
  import acs_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned TOL   = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   mclk_p_i,
  input  logic   frm_p_i,
  output logic   vld_o,
  output logic   match_o,
  output speed_e speed_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic               primed_q;
  logic [N_RATIO-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (frm_p_i) begin
      cnt_q    <= mclk_p_i ? CNT_W'(1) : '0;
      primed_q <= 1'b1;
    end else if (mclk_p_i && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N_RATIO; i++) begin : g_ratio
    localparam logic [CNT_W:0] REF = (CNT_W+1)'(ratio_tab(i));
    logic [CNT_W:0] diff;
    always_comb begin
      if ({1'b0, cnt_q} > REF) diff = {1'b0, cnt_q} - REF;
      else                     diff = REF - {1'b0, cnt_q};
    end
    assign hit[i] = (diff <= (CNT_W+1)'(TOL));
  end

  always_comb begin
    match_o = 1'b0;
    speed_o = SPD_NORMAL;
    for (int unsigned i = 0; i < N_RATIO; i++) begin
      if (hit[i]) begin
        match_o = 1'b1;
        speed_o = speed_tab(i);
      end
    end
  end

  // first window after a restart is partial and is thrown away
  assign vld_o = frm_p_i & primed_q & ~clr_i;

endmodule

// File: rtl/acs_ana_dly.sv
module acs_ana_dly #(
  parameter int unsigned DLY = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_alive_i,
  output logic ana_en_o
);
  localparam int unsigned DW = $clog2(DLY + 1);
  localparam logic [DW-1:0] LAST = DW'(DLY - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ana_en_o <= 1'b0;
    end else if (!mclk_alive_i) begin
      cnt_q    <= '0;
      ana_en_o <= 1'b0;
    end else if (!ana_en_o) begin
      if (cnt_q == LAST) ana_en_o <= 1'b1;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/acs_seq.sv
module acs_seq
  import acs_pkg::*;
#(
  parameter int unsigned MUTE_BASE  = 176,
  parameter int unsigned DIG_FRAMES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   all_alive_i,
  input  logic   frm_p_i,
  input  logic   vld_i,
  input  logic   match_i,
  input  speed_e meas_speed_i,
  output speed_e speed_o,
  output logic   dig_en_o,
  output logic   mute_o
);
  localparam int unsigned MW = $clog2(MUTE_BASE * 4 + 1);
  localparam int unsigned FW = $clog2(DIG_FRAMES + 1);
  localparam logic [FW-1:0] F_LAST = FW'(DIG_FRAMES - 1);

  seq_state_e    st_q;
  speed_e        spd_q;
  logic [FW-1:0] fcnt_q;
  logic [MW-1:0] mcnt_q;
  logic          fault;

  // a bad measurement outranks any frame-count progress in the same cycle
  assign fault = !all_alive_i || (vld_i && (!match_i || (meas_speed_i != spd_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      spd_q  <= SPD_NORMAL;
      fcnt_q <= '0;
      mcnt_q <= '0;
    end else begin
      case (st_q)
        ST_OFF: begin
          if (all_alive_i && vld_i && match_i) begin
            st_q   <= ST_WAIT;
            spd_q  <= meas_speed_i;
            fcnt_q <= '0;
          end
        end
        ST_WAIT: begin
          if (fault) st_q <= ST_OFF;
          else if (frm_p_i) begin
            if (fcnt_q == F_LAST) begin
              st_q   <= ST_MUTE;
              mcnt_q <= MW'(MUTE_BASE) << spd_q;
            end else begin
              fcnt_q <= fcnt_q + 1'b1;
            end
          end
        end
        ST_MUTE: begin
          if (fault) st_q <= ST_OFF;
          else if (frm_p_i) begin
            if (mcnt_q == MW'(1)) st_q   <= ST_RUN;
            else                  mcnt_q <= mcnt_q - 1'b1;
          end
        end
        default: begin
          if (fault) st_q <= ST_OFF;
        end
      endcase
    end
  end

  assign speed_o  = spd_q;
  assign dig_en_o = (st_q == ST_MUTE) || (st_q == ST_RUN);
  assign mute_o   = (st_q != ST_RUN);

endmodule

// File: rtl/audio_clk_supervisor.sv
module audio_clk_supervisor
  import acs_pkg::*;
#(
  parameter int unsigned MCLK_TO    = 64,
  parameter int unsigned BCLK_TO    = 256,
  parameter int unsigned FCLK_TO    = 16384,
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned TOL        = 2,
  parameter int unsigned MUTE_BASE  = 176,
  parameter int unsigned DIG_FRAMES = 2,
  parameter int unsigned ANA_DLY    = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_i,
  input  logic       bclk_i,
  input  logic       fclk_i,
  output logic [1:0] speed_o,
  output logic       dig_en_o,
  output logic       ana_en_o,
  output logic       mute_o
);
  localparam int unsigned N_CLK = 3;

  logic [N_CLK-1:0] clk_in, rise, alive;
  logic   all_alive, m_alive, m_rise, f_rise;
  logic   meas_vld, meas_match;
  speed_e meas_speed, seq_speed;

  assign clk_in = {fclk_i, bclk_i, mclk_i};

  for (genvar g = 0; g < N_CLK; g++) begin : g_mon
    localparam int unsigned TO = (g == 0) ? MCLK_TO : (g == 1) ? BCLK_TO : FCLK_TO;
    acs_edge_mon #(.TIMEOUT(TO)) u_mon (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (clk_in[g]),
      .rise_o  (rise[g]),
      .alive_o (alive[g])
    );
  end

  assign all_alive = &alive;
  assign m_alive   = alive[0];
  assign m_rise    = rise[0];
  assign f_rise    = rise[2];

  acs_ratio_meas #(.CNT_W(CNT_W), .TOL(TOL)) u_meas (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!all_alive),
    .mclk_p_i (m_rise),
    .frm_p_i  (f_rise),
    .vld_o    (meas_vld),
    .match_o  (meas_match),
    .speed_o  (meas_speed)
  );

  acs_seq #(.MUTE_BASE(MUTE_BASE), .DIG_FRAMES(DIG_FRAMES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .all_alive_i  (all_alive),
    .frm_p_i      (f_rise),
    .vld_i        (meas_vld),
    .match_i      (meas_match),
    .meas_speed_i (meas_speed),
    .speed_o      (seq_speed),
    .dig_en_o     (dig_en_o),
    .mute_o       (mute_o)
  );

  assign speed_o = seq_speed;

  acs_ana_dly #(.DLY(ANA_DLY)) u_ana (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mclk_alive_i (m_alive),
    .ana_en_o     (ana_en_o)
  );

endmodule

// File: rtl/acs_sva.sv
module acs_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       all_alive,
  input logic       m_alive,
  input logic       f_rise,
  input logic [1:0] speed_o,
  input logic       dig_en_o,
  input logic       ana_en_o,
  input logic       mute_o
);

  a_r5_dead_clock_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_alive |=> !dig_en_o);

  a_r9_ana_follows_mclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_alive |=> !ana_en_o);

  a_r7_enable_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dig_en_o) |-> $past(f_rise));

  a_r8_mute_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dig_en_o |-> mute_o);

  a_r8_unmute_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mute_o) |-> ($past(f_rise) && dig_en_o));

  a_r8_speed_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_en_o && $past(dig_en_o)) |-> (speed_o == $past(speed_o)));

endmodule

bind audio_clk_supervisor acs_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .all_alive (all_alive),
  .m_alive   (m_alive),
  .f_rise    (f_rise),
  .speed_o   (speed_o),
  .dig_en_o  (dig_en_o),
  .ana_en_o  (ana_en_o),
  .mute_o    (mute_o)
);

// File: tb/tb_audio_clk_supervisor.sv
`timescale 1ns/1ps
module tb_audio_clk_supervisor;
  localparam int MUTE_B = 3;
  localparam int ANA_D  = 50;
  localparam int WDOG   = 195000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mclk, bclk, fclk;
  logic [1:0] speed;
  logic dig_en, ana_en, mute;

  always #5 clk = ~clk;

  audio_clk_supervisor #(
    .MCLK_TO(32), .BCLK_TO(64), .FCLK_TO(5000), .CNT_W(12), .TOL(2),
    .MUTE_BASE(MUTE_B), .DIG_FRAMES(2), .ANA_DLY(ANA_D)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mclk_i(mclk), .bclk_i(bclk), .fclk_i(fclk),
    .speed_o(speed), .dig_en_o(dig_en), .ana_en_o(ana_en), .mute_o(mute)
  );

  // clock generator in reference-cycle units: mclk period 4, frame = ratio*4
  int ph = 0;
  int period = 2048;
  int ratio_next = 512;
  int frame_no = 0;
  bit run_m = 0, run_b = 0, run_f = 0;

  always @(negedge clk) begin
    if (ph >= period - 1) begin
      ph <= 0;
      period <= ratio_next * 4;
      if (run_f) frame_no <= frame_no + 1;
    end else begin
      ph <= ph + 1;
    end
  end

  assign fclk = run_f && (ph < period / 2);
  assign mclk = run_m && ph[1];
  assign bclk = run_b && ph[3];

  int checks = 0;
  int errors = 0;
  int done = 0;
  int cyc = 0;

  typedef struct {
    int    spd;
    int    n;
    int    fs;
    bit    abort;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic push_exp(input int spd, input int n, input int fs, input bit abort, input string tag);
    exp_t e;
    e.spd = spd; e.n = n; e.fs = fs; e.abort = abort; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_done(input int k);
    while (done < k) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic wait_frames(input int k);
    int f0;
    f0 = frame_no;
    while (frame_no < f0 + k) @(posedge clk);
  endtask

  function automatic string spd_req(input int s);
    return (s == 0) ? "R2" : "R3";
  endfunction

  // monitor: pops one expected sequence per rising dig_en
  initial begin
    exp_t e;
    int f0;
    forever begin
      do begin @(posedge clk); #2; end while (!dig_en);
      if (q.size() == 0) begin
        chk(1'b0, "R4 unexpected enable", 1, 0);
      end else begin
        e = q.pop_front();
        chk(speed == 2'(e.spd), spd_req(e.spd), int'(speed), e.spd);
        if (e.fs >= 0) chk(frame_no - e.fs == 4, "R7 enable frame", frame_no - e.fs, 4);
        chk(mute == 1'b1, "R8 muted at enable", int'(mute), 1);
        f0 = frame_no;
        do begin @(posedge clk); #2; end while (mute && dig_en);
        if (e.abort) begin
          chk(!dig_en && mute, "R10 fault wins over unmute", int'({dig_en, mute}), 1);
          chk(frame_no - f0 == e.n, "R10 fault frame", frame_no - f0, e.n);
        end else begin
          chk(dig_en && !mute, {e.tag, " R8 unmute"}, int'({dig_en, mute}), 2);
          chk(frame_no - f0 == e.n, {e.tag, " R8 hold frames"}, frame_no - f0, e.n);
        end
        done++;
      end
      while (dig_en) begin @(posedge clk); #2; end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver
  initial begin
    int fs;
    int x;
    repeat (5) @(posedge clk);
    #1;
    chk(!dig_en, "R1 dig_en in reset", int'(dig_en), 0);
    chk(mute, "R1 mute in reset", int'(mute), 1);
    chk(!ana_en, "R1 ana_en in reset", int'(ana_en), 0);
    chk(speed == 2'd0, "R1 speed in reset", int'(speed), 0);
    rst_ni = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    chk(!dig_en && mute, "R1 idle without clocks", int'({dig_en, mute}), 1);

    // start at a frame boundary, ratio 512; ratio drops to 256 on the
    // frame that closes exactly where the normal hold would end
    while (ph != period - 1) begin @(posedge clk); #1; end
    run_m = 1; run_b = 1; run_f = 1;
    @(posedge clk); #1;
    fs = frame_no;
    push_exp(0, MUTE_B, fs, 1'b1, "R10");
    push_exp(1, 2 * MUTE_B, -1, 1'b0, "R3 R6");
    repeat (30) @(posedge clk);
    #1;
    chk(!ana_en, "R9 ana_en before delay", int'(ana_en), 0);
    repeat (50) @(posedge clk);
    #1;
    chk(ana_en, "R9 ana_en after delay", int'(ana_en), 1);
    while (!dig_en) begin @(posedge clk); #1; end
    x = frame_no;
    while (frame_no < x + 1) begin @(posedge clk); #1; end
    ratio_next = 256;
    wait_done(2);

    // bit clock stops while running at double rate
    run_b = 0;
    repeat (200) @(posedge clk);
    #1;
    chk(!dig_en, "R5 dig_en with bclk dead", int'(dig_en), 0);
    chk(mute, "R5 mute with bclk dead", int'(mute), 1);
    chk(ana_en, "R9 ana_en kept with bclk dead", int'(ana_en), 1);
    push_exp(1, 2 * MUTE_B, -1, 1'b0, "R6");
    run_b = 1;
    wait_done(3);

    // quad rate 128
    push_exp(2, 4 * MUTE_B, -1, 1'b0, "R3");
    ratio_next = 128;
    wait_done(4);

    // illegal ratio 300
    ratio_next = 300;
    wait_frames(10);
    #1;
    chk(!dig_en, "R4 dig_en with bad ratio", int'(dig_en), 0);
    chk(mute, "R4 mute with bad ratio", int'(mute), 1);

    // quad rate 192
    push_exp(2, 4 * MUTE_B, -1, 1'b0, "R3 R6");
    ratio_next = 192;
    wait_done(5);

    // 510 is within tolerance of 512
    push_exp(0, MUTE_B, -1, 1'b0, "R2 tolerance");
    ratio_next = 510;
    wait_done(6);

    // master clock stops
    run_m = 0;
    repeat (100) @(posedge clk);
    #1;
    chk(!ana_en, "R9 ana_en with mclk dead", int'(ana_en), 0);
    chk(!dig_en && mute, "R5 off with mclk dead", int'({dig_en, mute}), 1);

    // restart at 1152
    push_exp(0, MUTE_B, -1, 1'b0, "R2 R6");
    ratio_next = 1152;
    run_m = 1;
    wait_done(7);
    chk(q.size() == 0, "R6 all sequences seen", q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule